// File: doc/BRIEF.md
# Slow-Infrared Bit-Rate Generator

This block produces the timing strobes for a slow infrared serial link. A fixed divide-by-26 stage brings the 48 MHz input clock down to a base rate. A programmable 6-bit reload counter then divides that base rate further. Each time the counter expires, the block emits a one-cycle sample strobe at sixteen times the bit rate. Every sixteenth sample strobe is also marked as a bit strobe. The resulting bit rate is 48 MHz / 26 / ((count + 1) * 16). A count of 11 gives the nominal 9600 bit/s rate that the link starts at.

A receive-idle timer runs alongside the dividers. It counts bit periods in which the receiver reported no line activity. When the programmed number of idle bit periods has passed, it raises a single timeout pulse, which tells the framing logic that a received frame has ended. The timer uses a 2-bit selector that only has meaning in the slow infrared mode. In every other mode the selector behaves as if it were zero.

Top module: `sir_rate_gen`

## Requirements
- R1: With count value N held steady, `sample_tick` pulses for one cycle every 26*(N+1) clock cycles.
- R2: `bit_tick` pulses on every sixteenth `sample_tick`, in the same cycle as that sample pulse. It is never high without `sample_tick`.
- R3: The count is 6 bits (0 to 63). A count of 11 gives a 312-cycle sample period and a 4992-cycle bit period, which is nominal 9600 bit/s from 48 MHz.
- R4: The count value is read only when the counter reloads. A change of `rate_cnt` therefore leaves the period already in progress at its old length, and the new length applies from the next period.
- R5: With `slow_mode` = 1 and `idle_sel` = 1, `timeout_pulse` is high for one cycle on the eighth `bit_tick` after the last line activity, in the same cycle as that bit pulse.
- R6: With `slow_mode` = 1 and `idle_sel` = 2, the timeout pulse comes on the sixteenth `bit_tick` after the last line activity.
- R7: `idle_sel` = 0 disables the timeout. The value 3 is invalid and is treated as 0. In both cases `timeout_pulse` stays low.
- R8: With `slow_mode` = 0, the selector is treated as 0 and no timeout pulse is produced.
- R9: A one-cycle `line_act` strobe restarts the idle count. After a timeout has fired, no further pulse comes until line activity has been seen again. Line activity in the same cycle as a bit pulse suppresses the timeout.
- R10: While reset is asserted, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_cnt | input | 6 | Reload value of the bit-rate counter |
| idle_sel | input | 2 | Idle timeout select: 0 off, 1 eight bits, 2 sixteen bits, 3 off |
| slow_mode | input | 1 | High when the link runs in slow infrared mode |
| line_act | input | 1 | One-cycle strobe marking receive line activity |
| sample_tick | output | 1 | One-cycle strobe at 16x the bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |
| timeout_pulse | output | 1 | One-cycle strobe when the idle limit is reached |

## Verification
The rate path is tried with count values 11, 0 and 63. The default value confirms the absolute 9600 bit/s spacing. Zero separates the prescaler period from the reload counter's period. Sixty-three exposes any truncation of the 6-bit field.

Each change of the count is made just after a sample pulse. This separates reading the count at reload from reading it at every step: the first interval after the change must keep the old length.

The idle timer is tried with each selector value, with slow mode off, and with activity that arrives partway through an idle run. Together these distinguish the two limits, the disabled encodings, the mode gating and the restart of the count. A long wait after each timeout shows the pulse fires only once.

// File: rtl/sir_rate_pkg.sv
package sir_rate_pkg;

  typedef enum logic [1:0] {
    IDLE_OFF   = 2'd0,
    IDLE_SHORT = 2'd1,
    IDLE_LONG  = 2'd2,
    IDLE_BAD   = 2'd3
  } idle_sel_e;

endpackage

// File: rtl/sir_prescaler.sv
module sir_prescaler #(
  parameter int DIV = 26
) (
  input  logic clk,
  input  logic rst_n,
  output logic pre_tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q, pre_d;

  always_comb begin
    pre_tick = (pre_q == LAST);
    if (pre_tick) pre_d = '0;
    else          pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R1
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);

  // R1
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

endmodule

// File: rtl/sir_rate_div.sv
module sir_rate_div #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic             fire,
  output logic             sample_tick
);
  logic [CNT_W-1:0] div_q, div_d;
  logic             smp_q;

  always_comb begin
    fire  = step && (div_q == '0);
    div_d = div_q;
    if (step) begin
      if (div_q == '0) div_d = reload_val;
      else             div_d = div_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      smp_q <= 1'b0;
    end else begin
      div_q <= div_d;
      smp_q <= fire;
    end
  end

  assign sample_tick = smp_q;

  // R4
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (div_q == $past(reload_val)));

  // R1
  sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

endmodule

// File: rtl/sir_bit_phase.sv
module sir_bit_phase #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic bit_fire,
  output logic bit_tick
);
  localparam int W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [W-1:0] LAST = W'(OVS - 1);

  logic [W-1:0] ph_q, ph_d;
  logic         bit_q;

  always_comb begin
    bit_fire = fire && (ph_q == LAST);
    ph_d     = ph_q;
    if (fire) begin
      if (bit_fire) ph_d = '0;
      else          ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_fire;
    end
  end

  assign bit_tick = bit_q;

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);

endmodule

// File: rtl/sir_idle_timer.sv
module sir_idle_timer
  import sir_rate_pkg::*;
#(
  parameter int SHORT_BITS = 8,
  parameter int LONG_BITS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_fire,
  input  logic       line_act,
  input  logic       slow_mode,
  input  logic [1:0] sel,
  output logic       timeout_pulse
);
  localparam int IW = $clog2(LONG_BITS + 1) + 1;
  localparam logic [IW-1:0] SAT = IW'(LONG_BITS);

  idle_sel_e     eff_sel;
  logic [IW-1:0] limit;
  logic [IW-1:0] idle_q, idle_d;
  logic          armed_q, armed_d;
  logic          hit;
  logic          tmo_q;

  always_comb begin
    eff_sel = slow_mode ? idle_sel_e'(sel) : IDLE_OFF;
    case (eff_sel)
      IDLE_SHORT: limit = IW'(SHORT_BITS);
      IDLE_LONG:  limit = IW'(LONG_BITS);
      default:    limit = '0;
    endcase
  end

  always_comb begin
    hit = bit_fire && armed_q && !line_act && (limit != '0) &&
          ((idle_q + 1'b1) >= limit);
    idle_d = idle_q;
    if (line_act)                     idle_d = '0;
    else if (bit_fire && idle_q != SAT) idle_d = idle_q + 1'b1;
    armed_d = armed_q;
    if (line_act) armed_d = 1'b1;
    else if (hit) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      armed_q <= 1'b1;
      tmo_q   <= 1'b0;
    end else begin
      idle_q  <= idle_d;
      armed_q <= armed_d;
      tmo_q   <= hit;
    end
  end

  assign timeout_pulse = tmo_q;

  // R9
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R8
  tmo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_mode |=> !timeout_pulse);

  // R9
  tmo_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_act |=> !timeout_pulse);

  // R7
  tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0 || sel == 2'd3) |=> !timeout_pulse);

endmodule

// File: rtl/sir_rate_gen.sv
module sir_rate_gen #(
  parameter int PRESCALE   = 26,
  parameter int CNT_W      = 6,
  parameter int OVS        = 16,
  parameter int SHORT_BITS = 8,
  parameter int LONG_BITS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rate_cnt,
  input  logic [1:0]       idle_sel,
  input  logic             slow_mode,
  input  logic             line_act,
  output logic             sample_tick,
  output logic             bit_tick,
  output logic             timeout_pulse
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       pre_tick;
  logic       fire;
  logic       bit_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sir_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pre_tick (pre_tick)
  );

  sir_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .step        (pre_tick),
    .reload_val  (rate_cnt),
    .fire        (fire),
    .sample_tick (sample_tick)
  );

  sir_bit_phase #(.OVS(OVS)) u_phase (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fire     (fire),
    .bit_fire (bit_fire),
    .bit_tick (bit_tick)
  );

  sir_idle_timer #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) u_idle (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .bit_fire      (bit_fire),
    .line_act      (line_act),
    .slow_mode     (slow_mode),
    .sel           (idle_sel),
    .timeout_pulse (timeout_pulse)
  );

  // R2
  bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R5
  tmo_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> bit_tick);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sample_tick && !bit_tick && !timeout_pulse));

endmodule

// File: tb/sir_rate_gen_tb.sv
module sir_rate_gen_tb;
  logic       clk;
  logic       rst_n;
  logic [5:0] rate_cnt;
  logic [1:0] idle_sel;
  logic       slow_mode;
  logic       line_act;
  logic       sample_tick;
  logic       bit_tick;
  logic       timeout_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur = 11;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];
  int    bexp_q[$];
  string btag_q[$];

  int  last_smp = -1;
  int  last_bit = -1;
  int  samp_since = 0;
  int  bits_since = 0;
  int  tmo_count = 0;
  int  tmo_at = -1;

  sir_rate_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate_cnt      (rate_cnt),
    .idle_sel      (idle_sel),
    .slow_mode     (slow_mode),
    .line_act      (line_act),
    .sample_tick   (sample_tick),
    .bit_tick      (bit_tick),
    .timeout_pulse (timeout_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard comparison and idle bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_act) bits_since = 0;
      if (sample_tick) begin
        samp_since++;
        if (last_smp >= 0 && exp_q.size() != 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cyc - last_smp == e, t, cyc - last_smp, e);
        end
        last_smp = cyc;
      end
      if (bit_tick) begin
        bits_since++;
        if (last_bit >= 0 && bexp_q.size() != 0) begin
          int e;
          string t;
          e = bexp_q.pop_front();
          t = btag_q.pop_front();
          check(cyc - last_bit == e, t, cyc - last_bit, e);
          // R2: sixteen sample pulses per bit, bit aligned to a sample
          check(samp_since == 16 && sample_tick, "R2", samp_since, 16);
        end
        last_bit = cyc;
        samp_since = 0;
      end
      if (timeout_pulse) begin
        tmo_count++;
        if (tmo_at < 0) tmo_at = bits_since;
      end
    end
  end

  task automatic after_sample();
    @(negedge clk);
    while (!sample_tick) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic after_bit();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // driver: change the count just after a reload and queue expected spacing
  task automatic run_rate(input int n, input int k, input string tag);
    after_sample();
    rate_cnt = 6'(n);
    exp_q.push_back(26 * (cur + 1));
    tag_q.push_back("R4");
    for (int i = 0; i < k; i++) begin
      exp_q.push_back(26 * (n + 1));
      tag_q.push_back(tag);
    end
    cur = n;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic run_bits(input int k, input string tag);
    after_bit();
    for (int i = 0; i < k; i++) begin
      bexp_q.push_back(416 * (cur + 1));
      btag_q.push_back(tag);
    end
    while (bexp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_act();
    line_act = 1'b1;
    @(posedge clk);
    #1;
    line_act = 1'b0;
  endtask

  task automatic idle_case(input bit slow, input int sel, input int wait_bits,
                           input int exp_cnt, input int exp_at, input string tag);
    after_bit();
    slow_mode = slow;
    idle_sel  = 2'(sel);
    pulse_act();
    tmo_count = 0;
    tmo_at = -1;
    while (bits_since < wait_bits) @(posedge clk);
    #1;
    check(tmo_count == exp_cnt, tag, tmo_count, exp_cnt);
    if (exp_cnt != 0) check(tmo_at == exp_at, tag, tmo_at, exp_at);
  endtask

  initial begin
    rst_n = 1'b0;
    rate_cnt = 6'd11;
    idle_sel = 2'd0;
    slow_mode = 1'b1;
    line_act = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    // R10
    check(!sample_tick && !bit_tick && !timeout_pulse, "R10",
          {29'd0, sample_tick, bit_tick, timeout_pulse}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R3 default spacing, then R1 extremes with R4 at each change
    run_rate(11, 3, "R3");
    run_bits(2, "R3");
    run_rate(0, 4, "R1");
    run_rate(63, 3, "R1");
    run_rate(5, 3, "R1");
    run_rate(0, 2, "R1");
    run_bits(2, "R2");

    // idle timeout behaviour at 416-cycle bit period
    idle_case(1'b1, 1, 12, 1, 8, "R5");
    idle_case(1'b1, 2, 20, 1, 16, "R6");
    idle_case(1'b1, 0, 20, 0, 0, "R7");
    idle_case(1'b1, 3, 20, 0, 0, "R7");
    idle_case(1'b0, 2, 20, 0, 0, "R8");

    // R9: activity midway restarts the idle count
    after_bit();
    slow_mode = 1'b1;
    idle_sel = 2'd1;
    pulse_act();
    while (bits_since < 5) @(posedge clk);
    #1;
    after_bit();
    pulse_act();
    tmo_count = 0;
    tmo_at = -1;
    while (bits_since < 14) @(posedge clk);
    #1;
    check(tmo_count == 1, "R9", tmo_count, 1);
    check(tmo_at == 8, "R9", tmo_at, 8);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule